// File: doc/BRIEF.md
# Stalling Clock-Crossing Register Bridge

This block connects a simple request/acknowledge register bus in a host clock domain to a small register file. The register file lives in a separate functional clock domain, and the two clocks have no fixed relation. Every access is nonposted. A write is carried into the functional domain and applied to the register file there. Only after that does the host see its acknowledge, and it stalls until then. A read makes the same full round trip: the register is sampled in the functional domain and the value comes back with the acknowledge.

The host raises `req_i` with `we_i`, `addr_i` and `wdata_i`. It keeps `req_i` high until `ack_o` pulses, then drops it. The request fields are captured when the request is accepted and are held steady while it crosses. A toggle handshake carries the request into the functional domain and the answer back, with a two-flop synchronizer in each direction. This makes the bridge correct whichever clock is faster. The full register file is presented on `regs_o` to logic in the functional domain.

Top module: `xdom_reg_bridge`

## Requirements
- R1: After both resets, `ack_o` is 0, `rdata_o` is 0, every register in `regs_o` is 0 and no transaction is pending.
- R2: When `ack_o` pulses for a write, the addressed register in `regs_o` already holds the written data.
- R3: Each accepted request produces exactly one `ack_o` pulse, one host cycle wide, and `ack_o` is never raised without a pending request.
- R4: `we_i`, `addr_i` and `wdata_i` are captured on the accepting host edge. Changes to them while the request is pending have no effect, and no second request is accepted before the acknowledge.
- R5: With the acknowledge of a read, `rdata_o` carries the addressed register's contents. With the acknowledge of a write, it carries the value just written.
- R6: A read that follows a write to the same register returns the newly written value.
- R7: Register g occupies `regs_o[g*DW +: DW]`. It changes only through a write whose address equals g. Reads leave every register unchanged.
- R8: R2 to R7 hold in three cases: the host clock faster than the functional clock, slower than it, or equal to it.
- R9: `ack_o` rises no earlier than three host clock edges after the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host clock |
| hrst_ni | input | 1 | Host domain asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register index |
| wdata_i | input | DW | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Returned data, valid with ack_o |
| fclk_i | input | 1 | Functional clock |
| frst_ni | input | 1 | Functional domain asynchronous reset, active low |
| regs_o | output | NREG*DW | Register file contents, register g at bits g*DW +: DW |

## Verification
The bench drives the same kinds of access under three clock ratios: a host clock well above the functional clock, one far below it, and the two equal. This separates synchronizer and handshake faults that only appear when one side samples much faster than the other. The patterns are:
- Writes to every index, to show that each register is decoded on its own.
- Immediate read-back of the same index, to catch a stale return path.
- Repeated reads, to show that reads have no side effect.
- Back-to-back writes to one index, to show that the latest value wins.

During every pending access the bench scrambles the request fields. On each host cycle it compares the whole register file with its model, which exposes an acknowledge that overtakes the update or a payload that is not held.

// File: rtl/xdom_pkg.sv
package xdom_pkg;
  typedef enum logic {
    H_IDLE = 1'b0,
    H_WAIT = 1'b1
  } host_st_e;
endpackage

// File: rtl/xdom_sync2.sv
module xdom_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/xdom_host.sv
module xdom_host
  import xdom_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic          hclk_i,
  input  logic          hrst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          x_tgl_o,
  output logic          x_we_o,
  output logic [AW-1:0] x_addr_o,
  output logic [DW-1:0] x_wdata_o,
  input  logic          x_ack_s_i,
  input  logic [DW-1:0] x_rdata_i
);
  host_st_e st_q;

  always_ff @(posedge hclk_i or negedge hrst_ni) begin
    if (!hrst_ni) begin
      st_q      <= H_IDLE;
      x_tgl_o   <= 1'b0;
      x_we_o    <= 1'b0;
      x_addr_o  <= '0;
      x_wdata_o <= '0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      ack_o <= 1'b0;
      unique case (st_q)
        H_IDLE: if (req_i && !ack_o) begin
          x_we_o    <= we_i;
          x_addr_o  <= addr_i;
          x_wdata_o <= wdata_i;
          x_tgl_o   <= ~x_tgl_o;
          st_q      <= H_WAIT;
        end
        H_WAIT: if (x_ack_s_i == x_tgl_o) begin
          // answer toggle caught up: functional side has acted
          ack_o   <= 1'b1;
          rdata_o <= x_rdata_i;
          st_q    <= H_IDLE;
        end
        default: st_q <= H_IDLE;
      endcase
    end
  end

  // R3
  ack_pulse_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    ack_o |=> !ack_o);
  // R3
  ack_owed_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    $rose(ack_o) |-> $past(st_q == H_WAIT));
  // R4
  hold_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    (st_q == H_WAIT && $past(st_q == H_WAIT)) |->
      ($stable(x_addr_o) && $stable(x_wdata_o) && $stable(x_we_o) && $stable(x_tgl_o)));
  // R9
  min_lat_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    $rose(ack_o) |-> ($past(st_q == H_WAIT, 1) && $past(st_q == H_WAIT, 2)));
endmodule

// File: rtl/xdom_func.sv
module xdom_func #(
  parameter int NREG = 4,
  parameter int AW   = 2,
  parameter int DW   = 32
) (
  input  logic                     fclk_i,
  input  logic                     frst_ni,
  input  logic                     x_req_s_i,
  input  logic                     x_we_i,
  input  logic [AW-1:0]            x_addr_i,
  input  logic [DW-1:0]            x_wdata_i,
  output logic                     x_ack_tgl_o,
  output logic [DW-1:0]            x_rdata_o,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  logic          seen_q;
  logic          act;
  logic [DW-1:0] rd_mux;

  assign act = (x_req_s_i != seen_q);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge fclk_i or negedge frst_ni) begin
      if (!frst_ni)                                      regs_o[g] <= '0;
      else if (act && x_we_i && x_addr_i == AW'(g))      regs_o[g] <= x_wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (x_addr_i == AW'(i)) rd_mux = regs_o[i];
  end

  always_ff @(posedge fclk_i or negedge frst_ni) begin
    if (!frst_ni) begin
      seen_q      <= 1'b0;
      x_ack_tgl_o <= 1'b0;
      x_rdata_o   <= '0;
    end else if (act) begin
      seen_q      <= x_req_s_i;
      x_rdata_o   <= x_we_i ? x_wdata_i : rd_mux;
      // answer toggles in the same edge that applies the write
      x_ack_tgl_o <= ~x_ack_tgl_o;
    end
  end

  // R7
  reg_hold_chk: assert property (@(posedge fclk_i) disable iff (!frst_ni)
    !(act && x_we_i) |=> $stable(regs_o));
  // R2
  wr_land_chk: assert property (@(posedge fclk_i) disable iff (!frst_ni)
    (act && x_we_i) |=> (regs_o[$past(x_addr_i)] == $past(x_wdata_i)));
  // R2
  ack_src_chk: assert property (@(posedge fclk_i) disable iff (!frst_ni)
    (x_ack_tgl_o != $past(x_ack_tgl_o)) |-> $past(act));
endmodule

// File: rtl/xdom_reg_bridge.sv
module xdom_reg_bridge #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              hclk_i,
  input  logic              hrst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ack_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              fclk_i,
  input  logic              frst_ni,
  output logic [NREG*DW-1:0] regs_o
);
  logic                    x_tgl, x_req_s, x_ack_tgl, x_ack_s, x_we;
  logic [AW-1:0]           x_addr;
  logic [DW-1:0]           x_wdata, x_rdata;
  logic [NREG-1:0][DW-1:0] regs;

  xdom_host #(.AW(AW), .DW(DW)) i_host (
    .hclk_i, .hrst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ack_o, .rdata_o,
    .x_tgl_o(x_tgl), .x_we_o(x_we), .x_addr_o(x_addr), .x_wdata_o(x_wdata),
    .x_ack_s_i(x_ack_s), .x_rdata_i(x_rdata)
  );

  xdom_sync2 i_req_sync (.clk_i(fclk_i), .rst_ni(frst_ni), .d_i(x_tgl),     .q_o(x_req_s));
  xdom_sync2 i_ack_sync (.clk_i(hclk_i), .rst_ni(hrst_ni), .d_i(x_ack_tgl), .q_o(x_ack_s));

  xdom_func #(.NREG(NREG), .AW(AW), .DW(DW)) i_func (
    .fclk_i, .frst_ni, .x_req_s_i(x_req_s), .x_we_i(x_we), .x_addr_i(x_addr),
    .x_wdata_i(x_wdata), .x_ack_tgl_o(x_ack_tgl), .x_rdata_o(x_rdata), .regs_o(regs)
  );

  assign regs_o = regs;
endmodule

// File: tb/test_xdom_reg_bridge.sv
`timescale 1ns/1ps
module test_xdom_reg_bridge;
  localparam int NREG = 4;
  localparam int DW   = 32;
  localparam int AW   = 2;

  logic hclk = 1'b0, fclk = 1'b0;
  logic hrst_n = 1'b0, frst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ack;
  logic [DW-1:0] rdata;
  logic [NREG*DW-1:0] regs;

  real fhalf = 18.5;
  int  checks = 0, fails = 0;
  bit  done = 1'b0;
  logic [DW-1:0] mdl [NREG];

  always #5 hclk = ~hclk;
  always #(fhalf) fclk = ~fclk;

  xdom_reg_bridge #(.NREG(NREG), .DW(DW)) i_xdom_reg_bridge (
    .hclk_i(hclk), .hrst_ni(hrst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .fclk_i(fclk),
    .frst_ni(frst_n), .regs_o(regs)
  );

  function automatic logic [DW-1:0] reg_at(int a);
    return regs[a*DW +: DW];
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic xact(bit w, int a, logic [DW-1:0] d);
    logic [DW-1:0] old_v = mdl[a];
    logic [DW-1:0] new_v = w ? d : mdl[a];
    int cyc = 0;
    bit got = 1'b0;
    @(negedge hclk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    while (!got) begin
      @(negedge hclk);
      cyc++;
      // R4: scramble fields while pending
      we = ~w; addr = AW'(a + 1); wdata = ~d ^ DW'(cyc);
      for (int i = 0; i < NREG; i++)
        if (i != a) chk(reg_at(i) == mdl[i], "R7 untouched register", reg_at(i), mdl[i]);
      if (ack) begin
        got = 1'b1;
        chk(reg_at(a) == new_v, "R2 register at ack", reg_at(a), new_v);
        chk(rdata == new_v, "R5 R6 returned data", rdata, new_v);
        chk(cyc >= 4, "R9 ack latency", DW'(cyc), 32'd4);
      end else begin
        chk(reg_at(a) == old_v || reg_at(a) == new_v, "R7 target before ack", reg_at(a), new_v);
        if (cyc > 3000) begin
          chk(1'b0, "R3 ack missing", 32'd0, 32'd1);
          got = 1'b1;
        end
      end
    end
    req = 1'b0;
    mdl[a] = new_v;
    @(negedge hclk);
    chk(ack == 1'b0, "R3 single ack pulse", DW'(ack), 32'd0);
    chk(reg_at(a) == new_v, "R4 R7 register after ack", reg_at(a), new_v);
  endtask

  task automatic run_set(logic [DW-1:0] seed);
    for (int i = 0; i < NREG; i++) xact(1'b1, i, seed ^ DW'(i * 32'h1111_0101));
    for (int i = 0; i < NREG; i++) xact(1'b0, i, '1);       // R5 R7 reads
    xact(1'b0, 2, 32'h0);                                    // R7 repeat read
    xact(1'b1, 1, seed + 32'h55);                            // R6 write then read
    xact(1'b0, 1, 32'h0);
    xact(1'b1, 3, 32'hFFFF_0000);
    xact(1'b1, 3, seed - 1);                                 // R6 latest wins
    xact(1'b0, 3, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge hclk);
      chk(ack == 1'b0, "R3 no ack when idle", DW'(ack), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    #100;
    @(negedge fclk) frst_n = 1'b1;
    @(negedge hclk) hrst_n = 1'b1;
    repeat (3) @(negedge hclk);
    // R1
    chk(ack == 1'b0, "R1 ack after reset", DW'(ack), 32'd0);
    chk(rdata == '0, "R1 rdata after reset", rdata, 32'd0);
    for (int i = 0; i < NREG; i++) chk(reg_at(i) == '0, "R1 register after reset", reg_at(i), 32'd0);
    // R8 host faster
    run_set(32'hA5A5_0001);
    // R8 host slower
    fhalf = 1.3;
    repeat (4) @(negedge hclk);
    run_set(32'h3C3C_7702);
    // R8 equal clocks
    fhalf = 5.0;
    repeat (4) @(negedge hclk);
    run_set(32'h0F1E_2D3C);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule